// File: doc/BRIEF.md
# Effective-to-Physical Address Translator

This block turns a 32-bit effective address into a 32-bit physical address for an instruction fetch or a data access. Every accepted request is looked up in two places in the same cycle: a small array of block-mapping registers, which cover aligned regions from 128 KB to 256 MB, and a 128-entry two-way set-associative page TLB with 4 KB pages. When a block entry matches, its result is used. Otherwise a TLB hit is used. When translation is off for the access type, the address goes through unchanged.

When translation is on and neither structure hits, the block raises a request to an external table-walk engine and stops taking new requests. It keeps the request up until the walker acknowledges with a refill. The refill is written into the TLB and the held access is then looked up again, so the requester gets its answer without further action. Block entries are written through a simple write port. Each entry carries its own privilege and write-protect bits.

Top module: `addr_xlate_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` and `walk_req` are 0 and `req_ready` is 1. All TLB entries and block entries are invalid after reset.
- R2: When the enable bit for the access type is 0 (`xen_fetch` when `req_is_fetch`=1, `xen_data` otherwise), the response gives `rsp_pa` equal to `req_ea` and raises no walk request, whatever the TLB and block contents.
- R3: On a page translation, `rsp_pa[31:12]` is the physical page number from the TLB entry and `rsp_pa[11:0]` equals `req_ea[11:0]`.
- R4: A block entry with base B (15 bits, compared with EA[31:17]), mask M (11 bits, over EA[27:17], contiguous ones from bit 0) and physical base P matches when EA[31:17] equals B in every bit where the zero-extended M is 0. It then gives PA[31:17] = (P & ~M) | (EA[31:17] & M) and PA[16:0] = EA[16:0]. The region size is 128 KB shifted left by the number of ones in M.
- R5: When a block entry and the TLB both match, the result comes from the block entry.
- R6: When several block entries match, the one with the lowest index wins.
- R7: A block entry counts as a match only if its supervisor-valid bit is set (for `req_sup`=1) or its user-valid bit is set (for `req_sup`=0).
- R8: A translated access that misses both structures raises `walk_req` with `walk_ea` equal to the access address. Both hold, with `req_ready` low and no response, until `refill_ack`. Two cycles after the acknowledge, the replayed access responds using the refilled entry.
- R9: A refill goes to way 0 if that way is invalid in the set, else to way 1 if that is invalid, else to the least recently used way. Any translated lookup that hits the TLB, and any refill, marks that way as most recently used.
- R10: `rsp_fault` is 1 exactly when a data write (`req_is_write`=1, `req_is_fetch`=0) is translated through a block entry or TLB entry whose write-protect bit is set. Fetches, reads and real-mode accesses never fault.
- R11: An accepted access that hits, or needs no translation, gives `rsp_valid` with its result in the next cycle.
- R12: The TLB set is selected by EA[17:12] and the stored tag is EA[31:18], so 64 sets of 2 ways hold 128 pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_ea | input | 32 | Effective address |
| req_is_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| req_is_write | input | 1 | Data write (ignored for fetches) |
| req_sup | input | 1 | Supervisor privilege level |
| xen_fetch | input | 1 | Translation enable for fetches |
| xen_data | input | 1 | Translation enable for data accesses |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Write-protect violation |
| walk_req | output | 1 | Table-walk request |
| walk_ea | output | 32 | Address to walk |
| refill_ack | input | 1 | Walker refill strobe |
| refill_ppn | input | 20 | Physical page number for the refill |
| refill_ro | input | 1 | Write-protect bit for the refill |
| bw_en | input | 1 | Block entry write strobe |
| bw_idx | input | 2 | Block entry index |
| bw_base | input | 15 | Block effective base EA[31:17] |
| bw_mask | input | 11 | Block size mask |
| bw_phys | input | 15 | Block physical base PA[31:17] |
| bw_sup_ok | input | 1 | Entry valid in supervisor mode |
| bw_usr_ok | input | 1 | Entry valid in user mode |
| bw_ro | input | 1 | Entry is write protected |

## Verification
The bench uses the default parameters: four block entries and 64 TLB sets. With four entries it can place overlapping regions, one supervisor-only and one user-only, so R5, R6 and R7 can be reached together. With 64 sets, directed accesses can fill one set past its two ways and show the eviction order. The random phase draws page addresses from a few sets and tags, so set conflicts, LRU evictions and replays come up often.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int EA_W       = 32;
  localparam int PG_OFS     = 12;
  localparam int BLK_OFS    = 17;
  localparam int BLK_HI_W   = EA_W - BLK_OFS;
  localparam int BLK_MASK_W = 11;
  localparam int PPN_W      = EA_W - PG_OFS;

  typedef struct packed {
    logic [BLK_HI_W-1:0]   base;
    logic [BLK_MASK_W-1:0] mask;
    logic [BLK_HI_W-1:0]   phys;
    logic                  sup_ok;
    logic                  usr_ok;
    logic                  ro;
  } blk_ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REPLAY} xl_state_e;
endpackage

// File: rtl/xlate_blk_array.sv
module xlate_blk_array import xlate_pkg::*; #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  blk_ent_t            wr_ent,
  input  logic [BLK_HI_W-1:0] lk_hi,
  input  logic                lk_sup,
  output logic                hit,
  output logic [BLK_HI_W-1:0] pa_hi,
  output logic                ro
);
  logic [N-1:0]          match;
  logic [BLK_HI_W-1:0]   cand_pa [N];
  logic [N-1:0]          cand_ro;

  for (genvar g = 0; g < N; g++) begin : g_ent
    blk_ent_t            ent_q;
    logic [BLK_HI_W-1:0] wmask;

    always_ff @(posedge clk) begin
      if (rst)                                    ent_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      ent_q <= wr_ent;
    end

    assign wmask      = {{(BLK_HI_W-BLK_MASK_W){1'b0}}, ent_q.mask};
    assign match[g]   = (((lk_hi ^ ent_q.base) & ~wmask) == '0) &&
                        (lk_sup ? ent_q.sup_ok : ent_q.usr_ok);
    assign cand_pa[g] = (ent_q.phys & ~wmask) | (lk_hi & wmask);
    assign cand_ro[g] = ent_q.ro;
  end

  // lowest index has priority: scan downward so it is assigned last
  always_comb begin
    hit   = 1'b0;
    pa_hi = '0;
    ro    = 1'b0;
    for (int i = N-1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        pa_hi = cand_pa[i];
        ro    = cand_ro[i];
      end
    end
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb import xlate_pkg::*; #(
  parameter int SET_W = 6,
  localparam int NSETS = 1 << SET_W,
  localparam int TAG_W = PPN_W - SET_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PPN_W-1:0] lk_vpn,
  input  logic             touch_en,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output logic             ro,
  input  logic             wr_en,
  input  logic [PPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_ro
);
  logic [SET_W-1:0] lk_set, wr_set;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic [1:0]       way_hit, wr_vld;
  logic [PPN_W:0]   rd_dat [2];
  logic             vic_way, hit_way;
  logic [NSETS-1:0] lru_q;

  assign lk_set = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[PPN_W-1:SET_W];
  assign wr_set = wr_vpn[SET_W-1:0];
  assign wr_tag = wr_vpn[PPN_W-1:SET_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [NSETS];
    logic [PPN_W:0]   dat_mem [NSETS];
    logic [NSETS-1:0] vld_q;

    always_ff @(posedge clk) begin
      if (wr_en && vic_way == 1'(w)) begin
        tag_mem[wr_set] <= wr_tag;
        dat_mem[wr_set] <= {wr_ro, wr_ppn};
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                              vld_q <= '0;
      else if (wr_en && vic_way == 1'(w))   vld_q[wr_set] <= 1'b1;
    end

    assign way_hit[w] = vld_q[lk_set] && (tag_mem[lk_set] == lk_tag);
    assign rd_dat[w]  = dat_mem[lk_set];
    assign wr_vld[w]  = vld_q[wr_set];
  end

  assign hit     = |way_hit;
  assign hit_way = ~way_hit[0];
  assign ppn     = hit_way ? rd_dat[1][PPN_W-1:0] : rd_dat[0][PPN_W-1:0];
  assign ro      = hit_way ? rd_dat[1][PPN_W]     : rd_dat[0][PPN_W];

  always_comb begin
    if (!wr_vld[0])      vic_way = 1'b0;
    else if (!wr_vld[1]) vic_way = 1'b1;
    else                 vic_way = lru_q[wr_set];
  end

  // lru_q names the way to evict next
  always_ff @(posedge clk) begin
    if (rst)                   lru_q <= '0;
    else if (wr_en)            lru_q[wr_set] <= ~vic_way;
    else if (touch_en && hit)  lru_q[lk_set] <= ~hit_way;
  end
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top import xlate_pkg::*; #(
  parameter int BLK_ENTRIES = 4,
  parameter int TLB_SET_W   = 6,
  localparam int BIDX_W = (BLK_ENTRIES > 1) ? $clog2(BLK_ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [EA_W-1:0]       req_ea,
  input  logic                  req_is_fetch,
  input  logic                  req_is_write,
  input  logic                  req_sup,
  input  logic                  xen_fetch,
  input  logic                  xen_data,
  output logic                  rsp_valid,
  output logic [EA_W-1:0]       rsp_pa,
  output logic                  rsp_fault,
  output logic                  walk_req,
  output logic [EA_W-1:0]       walk_ea,
  input  logic                  refill_ack,
  input  logic [PPN_W-1:0]      refill_ppn,
  input  logic                  refill_ro,
  input  logic                  bw_en,
  input  logic [BIDX_W-1:0]     bw_idx,
  input  logic [BLK_HI_W-1:0]   bw_base,
  input  logic [BLK_MASK_W-1:0] bw_mask,
  input  logic [BLK_HI_W-1:0]   bw_phys,
  input  logic                  bw_sup_ok,
  input  logic                  bw_usr_ok,
  input  logic                  bw_ro
);
  xl_state_e       st_q;
  logic [EA_W-1:0] pend_ea_q;
  logic            pend_fetch_q, pend_wr_q, pend_sup_q;

  logic            go_new, lk_go, replay;
  logic [EA_W-1:0] lk_ea;
  logic            lk_fetch, lk_wr, lk_sup, lk_store, xlate_on;

  logic                blk_hit, blk_ro;
  logic [BLK_HI_W-1:0] blk_pa_hi;
  logic                tlb_hit, tlb_ro;
  logic [PPN_W-1:0]    tlb_ppn;

  logic            res_miss, res_fault;
  logic [EA_W-1:0] res_pa;
  blk_ent_t        bw_ent;

  assign req_ready = (st_q == ST_IDLE);
  assign walk_req  = (st_q == ST_WALK);
  assign walk_ea   = pend_ea_q;
  assign go_new    = req_ready && req_valid;
  assign replay    = (st_q == ST_REPLAY);
  assign lk_go     = go_new || replay;

  assign lk_ea    = replay ? pend_ea_q    : req_ea;
  assign lk_fetch = replay ? pend_fetch_q : req_is_fetch;
  assign lk_wr    = replay ? pend_wr_q    : req_is_write;
  assign lk_sup   = replay ? pend_sup_q   : req_sup;
  assign lk_store = lk_wr && !lk_fetch;
  assign xlate_on = lk_fetch ? xen_fetch : xen_data;

  assign bw_ent = '{base: bw_base, mask: bw_mask, phys: bw_phys,
                    sup_ok: bw_sup_ok, usr_ok: bw_usr_ok, ro: bw_ro};

  xlate_blk_array #(.N(BLK_ENTRIES)) i_blk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bw_en),
    .wr_idx (bw_idx),
    .wr_ent (bw_ent),
    .lk_hi  (lk_ea[EA_W-1:BLK_OFS]),
    .lk_sup (lk_sup),
    .hit    (blk_hit),
    .pa_hi  (blk_pa_hi),
    .ro     (blk_ro)
  );

  xlate_tlb #(.SET_W(TLB_SET_W)) i_tlb (
    .clk      (clk),
    .rst      (rst),
    .lk_vpn   (lk_ea[EA_W-1:PG_OFS]),
    .touch_en (lk_go && xlate_on),
    .hit      (tlb_hit),
    .ppn      (tlb_ppn),
    .ro       (tlb_ro),
    .wr_en    (walk_req && refill_ack),
    .wr_vpn   (pend_ea_q[EA_W-1:PG_OFS]),
    .wr_ppn   (refill_ppn),
    .wr_ro    (refill_ro)
  );

  always_comb begin
    res_miss  = 1'b0;
    res_fault = 1'b0;
    res_pa    = lk_ea;
    if (xlate_on) begin
      if (blk_hit) begin
        res_pa    = {blk_pa_hi, lk_ea[BLK_OFS-1:0]};
        res_fault = lk_store && blk_ro;
      end else if (tlb_hit) begin
        res_pa    = {tlb_ppn, lk_ea[PG_OFS-1:0]};
        res_fault = lk_store && tlb_ro;
      end else begin
        res_miss  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_pa       <= '0;
      pend_ea_q    <= '0;
      pend_fetch_q <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_sup_q   <= 1'b0;
    end else begin
      rsp_valid <= lk_go && !res_miss;
      rsp_fault <= lk_go && !res_miss && res_fault;
      if (lk_go && !res_miss) rsp_pa <= res_pa;
      if (go_new) begin
        pend_ea_q    <= req_ea;
        pend_fetch_q <= req_is_fetch;
        pend_wr_q    <= req_is_write;
        pend_sup_q   <= req_sup;
      end
      unique case (st_q)
        ST_IDLE:   if (go_new && res_miss) st_q <= ST_WALK;
        ST_WALK:   if (refill_ack)         st_q <= ST_REPLAY;
        ST_REPLAY: st_q <= res_miss ? ST_WALK : ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addr_xlate_checker.sv
module addr_xlate_checker (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_ea,
  input logic        req_is_fetch,
  input logic        req_is_write,
  input logic        xen_fetch,
  input logic        xen_data,
  input logic        rsp_valid,
  input logic [31:0] rsp_pa,
  input logic        rsp_fault,
  input logic        walk_req,
  input logic [31:0] walk_ea,
  input logic        refill_ack
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!walk_req && !rsp_valid && req_ready));

  a_r8_walk_holds: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !refill_ack) |=> walk_req);

  a_r8_walk_ea_stable: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !refill_ack) |=> $stable(walk_ea));

  a_r8_blocked_while_walking: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> (!req_ready && !rsp_valid));

  a_r2_real_mode_passes: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_ready &&
          (req_is_fetch ? !xen_fetch : !xen_data))
    |-> (rsp_valid && !rsp_fault && rsp_pa == $past(req_ea)));

  a_r11_answer_or_walk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && req_ready) |-> (rsp_valid || walk_req));

  a_r10_fault_needs_store: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && $past(req_valid && req_ready))
    |-> (rsp_valid && $past(req_is_write && !req_is_fetch)));

  a_r10_fault_with_valid: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid);
endmodule

bind addr_xlate_top addr_xlate_checker i_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_ea       (req_ea),
  .req_is_fetch (req_is_fetch),
  .req_is_write (req_is_write),
  .xen_fetch    (xen_fetch),
  .xen_data     (xen_data),
  .rsp_valid    (rsp_valid),
  .rsp_pa       (rsp_pa),
  .rsp_fault    (rsp_fault),
  .walk_req     (walk_req),
  .walk_ea      (walk_ea),
  .refill_ack   (refill_ack)
);

// File: tb/test_addr_xlate_top.sv
module test_addr_xlate_top;
  localparam int NB = 4;
  localparam int SW = 6;
  localparam int NS = 1 << SW;
  localparam int TW = 20 - SW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_is_fetch = 1'b0, req_is_write = 1'b0, req_sup = 1'b0;
  logic [31:0] req_ea = '0;
  logic        xen_fetch = 1'b0, xen_data = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault, walk_req;
  logic [31:0] rsp_pa, walk_ea;
  logic        refill_ack = 1'b0, refill_ro = 1'b0;
  logic [19:0] refill_ppn = '0;
  logic        bw_en = 1'b0, bw_sup_ok = 1'b0, bw_usr_ok = 1'b0, bw_ro = 1'b0;
  logic [1:0]  bw_idx = '0;
  logic [14:0] bw_base = '0, bw_phys = '0;
  logic [10:0] bw_mask = '0;

  always #2 clk = ~clk;

  addr_xlate_top #(.BLK_ENTRIES(NB), .TLB_SET_W(SW)) i_addr_xlate_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_is_fetch(req_is_fetch), .req_is_write(req_is_write),
    .req_sup(req_sup), .xen_fetch(xen_fetch), .xen_data(xen_data),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .walk_req(walk_req), .walk_ea(walk_ea), .refill_ack(refill_ack),
    .refill_ppn(refill_ppn), .refill_ro(refill_ro), .bw_en(bw_en),
    .bw_idx(bw_idx), .bw_base(bw_base), .bw_mask(bw_mask), .bw_phys(bw_phys),
    .bw_sup_ok(bw_sup_ok), .bw_usr_ok(bw_usr_ok), .bw_ro(bw_ro)
  );

  // reference model state
  bit          m_vld [NS][2];
  logic [TW-1:0] m_tag [NS][2];
  logic [19:0] m_ppn [NS][2];
  bit          m_ro  [NS][2];
  bit          m_lru [NS];
  logic [14:0] b_base [NB], b_phys [NB];
  logic [10:0] b_mask [NB];
  bit          b_sup [NB], b_usr [NB], b_ro [NB];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_ppn(input logic [19:0] vpn);
    return vpn ^ 20'h5A3C1;
  endfunction

  function automatic void model_look(input logic [31:0] ea, input bit f, input bit w,
      input bit s, output bit on, output bit miss, output logic [31:0] pa,
      output bit flt, output bit via_blk, output bit thit, output int tway);
    int set;
    bit store;
    bit done_b;
    logic [14:0] wm;
    on = f ? xen_fetch : xen_data;
    store = w && !f;
    miss = 0; flt = 0; via_blk = 0; thit = 0; tway = 0; pa = ea;
    set = int'(ea[17:12]);
    for (int k = 1; k >= 0; k--)
      if (m_vld[set][k] && m_tag[set][k] == ea[31:18]) begin thit = 1; tway = k; end
    if (!on) return;
    done_b = 0;
    for (int i = 0; i < NB; i++) begin
      wm = {4'b0, b_mask[i]};
      if (!done_b && (((ea[31:17] ^ b_base[i]) & ~wm) == 15'd0) && (s ? b_sup[i] : b_usr[i])) begin
        done_b = 1; via_blk = 1;
        pa = {(b_phys[i] & ~wm) | (ea[31:17] & wm), ea[16:0]};
        flt = store && b_ro[i];
      end
    end
    if (done_b) return;
    if (thit) begin
      pa = {m_ppn[set][tway], ea[11:0]};
      flt = store && m_ro[set][tway];
    end else miss = 1;
  endfunction

  task automatic model_refill(input logic [31:0] ea);
    int set, way;
    set = int'(ea[17:12]);
    if (!m_vld[set][0]) way = 0;
    else if (!m_vld[set][1]) way = 1;
    else way = int'(m_lru[set]);
    m_vld[set][way] = 1;
    m_tag[set][way] = ea[31:18];
    m_ppn[set][way] = mk_ppn(ea[31:12]);
    m_ro[set][way]  = ea[15];
    m_lru[set]      = (way == 0);
  endtask

  task automatic compare(input logic [31:0] ea, input bit f, input bit w, input bit s,
                         input string tag);
    bit on, miss, flt, vb, th; int tw;
    logic [31:0] pa;
    model_look(ea, f, w, s, on, miss, pa, flt, vb, th, tw);
    if (on && th) m_lru[int'(ea[17:12])] = (tw == 0);
    chk(rsp_valid === 1'b1, "R11", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(rsp_pa === pa, tag, "rsp_pa", rsp_pa, pa);
    chk(rsp_fault === flt, "R10", "rsp_fault", {31'd0, rsp_fault}, {31'd0, flt});
  endtask

  task automatic access(input logic [31:0] ea, input bit f, input bit w, input bit s,
                        input string tag, output bit walked);
    bit on, miss, flt, vb, th; int tw;
    logic [31:0] pa;
    int dly;
    model_look(ea, f, w, s, on, miss, pa, flt, vb, th, tw);
    walked = 0;
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_is_fetch = f; req_is_write = w; req_sup = s;
    @(negedge clk);
    req_valid = 0;
    if (!miss) begin
      compare(ea, f, w, s, tag);
      chk(walk_req === 1'b0, "R8", "no walk on hit", {31'd0, walk_req}, 32'd0);
    end else begin
      walked = 1;
      chk(walk_req === 1'b1 && rsp_valid === 1'b0, "R8", "walk raised",
          {30'd0, walk_req, rsp_valid}, 32'd2);
      chk(walk_ea === ea, "R8", "walk_ea", walk_ea, ea);
      chk(req_ready === 1'b0, "R8", "ready low while walking", {31'd0, req_ready}, 32'd0);
      dly = int'($urandom % 3);
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(walk_req === 1'b1 && rsp_valid === 1'b0, "R8", "walk held",
            {30'd0, walk_req, rsp_valid}, 32'd2);
      end
      refill_ack = 1; refill_ppn = mk_ppn(ea[31:12]); refill_ro = ea[15];
      @(negedge clk);
      refill_ack = 0;
      model_refill(ea);
      @(negedge clk);
      compare(ea, f, w, s, "R8");
      chk(walk_req === 1'b0, "R8", "walk dropped", {31'd0, walk_req}, 32'd0);
    end
  endtask

  task automatic prog_blk(input int i, input logic [14:0] base, input logic [10:0] mask,
                          input logic [14:0] phys, input bit su, input bit us, input bit ro);
    @(negedge clk);
    bw_en = 1; bw_idx = 2'(i); bw_base = base; bw_mask = mask; bw_phys = phys;
    bw_sup_ok = su; bw_usr_ok = us; bw_ro = ro;
    @(negedge clk);
    bw_en = 0;
    b_base[i] = base; b_mask[i] = mask; b_phys[i] = phys;
    b_sup[i] = su; b_usr[i] = us; b_ro[i] = ro;
  endtask

  function automatic string path_tag(input logic [31:0] ea, input bit f, input bit w,
                                     input bit s);
    bit on, miss, flt, vb, th; int tw;
    logic [31:0] pa;
    model_look(ea, f, w, s, on, miss, pa, flt, vb, th, tw);
    if (!on) return "R2";
    if (vb) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit wk;
    logic [31:0] a, b, c, d, ea;
    void'($urandom(32'd42));
    for (int i = 0; i < NB; i++) begin
      b_base[i] = '0; b_mask[i] = '0; b_phys[i] = '0; b_sup[i] = 0; b_usr[i] = 0; b_ro[i] = 0;
    end
    for (int i = 0; i < NS; i++) begin
      m_lru[i] = 0;
      for (int k = 0; k < 2; k++) begin
        m_vld[i][k] = 0; m_tag[i][k] = '0; m_ppn[i][k] = '0; m_ro[i][k] = 0;
      end
    end
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && walk_req === 1'b0 && req_ready === 1'b1, "R1",
        "outputs in reset", {29'd0, rsp_valid, walk_req, req_ready}, 32'd1);
    rst = 0;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && walk_req === 1'b0 && req_ready === 1'b1, "R1",
        "outputs after reset", {29'd0, rsp_valid, walk_req, req_ready}, 32'd1);

    // R2: real mode, per access type
    access(32'h1234_5678, 1, 0, 1, "R2", wk);
    chk(wk == 0, "R2", "no walk in real mode", {31'd0, wk}, 32'd0);
    xen_fetch = 1; xen_data = 0;
    access(32'hCAFE_0ABC, 0, 1, 0, "R2", wk);
    chk(wk == 0, "R2", "data real while fetch translated", {31'd0, wk}, 32'd0);
    access(32'h0040_1000, 1, 0, 0, "R3", wk);
    chk(wk == 1, "R1", "TLB empty after reset", {31'd0, wk}, 32'd1);
    xen_data = 1;

    // R9 / R12: three tags in set 5
    a = {14'd1, 6'd5, 12'h0AB};
    b = {14'd2, 6'd5, 12'h1C0};
    c = {14'd3, 6'd5, 12'h004};
    d = {14'd1, 6'd4, 12'h0AB};
    access(a, 0, 0, 0, "R3", wk); chk(wk == 1, "R9", "A first miss", {31'd0, wk}, 32'd1);
    access(b, 0, 0, 0, "R3", wk); chk(wk == 1, "R9", "B fills way 1", {31'd0, wk}, 32'd1);
    access(a, 0, 0, 0, "R3", wk); chk(wk == 0, "R9", "A hit", {31'd0, wk}, 32'd0);
    access(b, 0, 0, 0, "R3", wk); chk(wk == 0, "R9", "B hit", {31'd0, wk}, 32'd0);
    access(a, 1, 0, 1, "R3", wk); chk(wk == 0, "R9", "A touched", {31'd0, wk}, 32'd0);
    access(c, 0, 0, 0, "R3", wk); chk(wk == 1, "R9", "C evicts LRU", {31'd0, wk}, 32'd1);
    access(a, 0, 0, 0, "R3", wk); chk(wk == 0, "R9", "A kept", {31'd0, wk}, 32'd0);
    access(b, 0, 0, 0, "R3", wk); chk(wk == 1, "R9", "B evicted", {31'd0, wk}, 32'd1);
    access(d, 0, 0, 0, "R12", wk); chk(wk == 1, "R12", "other set misses", {31'd0, wk}, 32'd1);
    access(d, 0, 0, 0, "R12", wk); chk(wk == 0, "R12", "other set hit", {31'd0, wk}, 32'd0);
    access(a ^ 32'h0004_0000, 0, 0, 0, "R12", wk);
    chk(wk == 1, "R12", "tag bit 18 distinguishes", {31'd0, wk}, 32'd1);

    // block entries
    prog_blk(0, 15'h4000, 11'h000, 15'h0123, 1, 1, 0);
    prog_blk(1, 15'h4000, 11'h7FF, 15'h1000, 1, 0, 1);
    prog_blk(2, 15'h7000, 11'h00F, 15'h0200, 0, 1, 0);
    access(32'h8001_0040, 0, 0, 1, "R6", wk);
    chk(rsp_pa === 32'h0247_0040, "R6", "lowest index wins", rsp_pa, 32'h0247_0040);
    access(32'h8ABC_1234, 0, 0, 1, "R4", wk);
    chk(rsp_pa === 32'h2ABC_1234, "R4", "256MB block pa", rsp_pa, 32'h2ABC_1234);
    access(32'h8ABC_1234, 0, 1, 1, "R10", wk);
    chk(rsp_fault === 1'b1, "R10", "store to protected block", {31'd0, rsp_fault}, 32'd1);
    access(32'h8ABC_1234, 1, 1, 1, "R10", wk);
    chk(rsp_fault === 1'b0, "R10", "fetch never faults", {31'd0, rsp_fault}, 32'd0);
    access(32'h8ABC_1234, 0, 0, 0, "R7", wk);
    chk(wk == 1, "R7", "user ignores supervisor-only block", {31'd0, wk}, 32'd1);
    access(32'h8ABC_1234, 0, 0, 1, "R5", wk);
    chk(wk == 0 && rsp_pa === 32'h2ABC_1234, "R5", "block overrides TLB", rsp_pa, 32'h2ABC_1234);
    access(32'hE012_3456, 0, 0, 0, "R7", wk);
    chk(wk == 0, "R7", "user-only block serves user", {31'd0, wk}, 32'd0);
    access(32'hE012_3456, 0, 0, 1, "R7", wk);
    chk(wk == 1, "R7", "user-only block ignored for supervisor", {31'd0, wk}, 32'd1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int r;
      bit f, w, s;
      r = int'($urandom % 6);
      unique case (r)
        0: ea = 32'h8000_0000 | ($urandom & 32'h0001_FFFF);
        1: ea = 32'h8000_0000 | ($urandom & 32'h0FFF_FFFF);
        2: ea = 32'hE000_0000 | ($urandom & 32'h001F_FFFF);
        3, 5: ea = {12'($urandom % 3) + 12'h010, 2'($urandom), 6'($urandom % 4), 12'($urandom)};
        default: ea = $urandom;
      endcase
      f = 1'($urandom); w = 1'($urandom); s = 1'($urandom);
      if ($urandom % 20 == 0) begin
        xen_fetch = 1'($urandom); xen_data = 1'($urandom);
      end
      if ($urandom % 40 == 0) begin
        int k;
        k = int'($urandom % 12);
        prog_blk(3, 15'($urandom), 11'((1 << k) - 1), 15'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));
      end
      access(ea, f, w, s, path_tag(ea, f, w, s), wk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule